// File: doc/BRIEF.md
# Serial presence detect byte-read engine

This block fetches a single byte from the configuration EEPROM on a memory module over a two-wire serial bus. Software writes one 32-bit command word. The top nibble holds the device type, three bits select which module is addressed, and one byte gives the location to read. The engine then runs a complete random-address read on the bus. Software polls a 16-bit status word until the busy flag drops. It then accepts the returned byte only if the data-valid flag is set and the error flag is clear.

The 7-bit bus address is the device type followed by the module select. The bus sequence is:

1. START.
2. Address with the write bit.
3. Byte address.
4. Repeated START.
5. Address with the read bit.
6. One data byte, answered with NACK.
7. STOP.

A missing acknowledge on any of the three phases the engine sends ends the transfer early with a STOP and reports an error. The serial clock comes from the system clock through a divider. `QDIV` system cycles make one quarter of a bit period, so a complete read takes 156·`QDIV` cycles. Both bus pins are open-drain: the block only ever pulls them low.

Top module: `spd_read_engine`

## Requirements
- R1: After reset the status word reads 0x0000 and neither bus line is pulled low.
- R2: A command word with bit 0 = 0 starts a read. The bus address is {cmd[31:28], cmd[26:24]} and the byte address is cmd[23:16]. Bit 27, bits 15:8 and bits 7:1 have no effect. On success the status reads 0x8000 | data: bit 15 data-valid, bit 13 error, bit 12 busy, bits 7:0 the byte, and all other bits 0.
- R3: On the clock edge that accepts a command, busy is set and data-valid, error and the data byte are cleared. The next status read gives 0x1000.
- R4: A command written while busy is set is ignored. The running read completes with its own address and data.
- R5: A command word with bit 0 = 1 is ignored. The status does not change and the bus stays released.
- R6: A missing acknowledge on the write-address, byte-address or read-address phase ends with STOP, busy cleared and status 0x2000. Data-valid and error are never set together.
- R7: SDA changes while SCL is high only for START, repeated START and STOP. A full read shows exactly 3 such SDA edges. A read cut short at the write-address or byte-address phase shows 2.
- R8: Busy stays set for between 156·QDIV and 156·QDIV+4 clock cycles per read.
- R9: Whenever the engine is idle, both bus lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | One-cycle write strobe for the command word |
| cmd_wdata | input | 32 | Command word |
| stat_rdata | output | 16 | Status word (data-valid, error, busy, byte) |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
Reads are swept over byte addresses that cover 0, 255 and a stride through the space. An EEPROM model in the bench returns a byte computed arithmetically from the address. This confirms that the address byte and the eight sampled data bits are assembled in the right order, while the junk bits in the command word vary. Separate runs withhold the acknowledge at each of the three phases, or use a wrong module select or a wrong device type. These runs tell the early-STOP paths apart by their status word and by the count of SDA edges seen while SCL is high. Commands written during a transfer, and commands with the command bit set, show whether stray writes are ignored.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_BYTE, PH_STOP} spd_phase_e;
  localparam int SLOTS_PER_READ = 39;  // 2 starts, 4 bytes of 9 bits, 1 stop
  localparam int QUARTERS       = 4;
  localparam int ST_VALID_BIT   = 15;
  localparam int ST_ERR_BIT     = 13;
  localparam int ST_BUSY_BIT    = 12;
endpackage

// File: rtl/spd_qtick.sv
module spd_qtick #(
  parameter int QDIV = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick_o = run_i && (cnt == LAST);
endmodule

// File: rtl/spd_seq.sv
module spd_seq
  import spd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [6:0] dev_i,
  input  logic [7:0] baddr_i,
  input  logic       tick_i,
  input  logic       sda_in_i,
  output logic       scl_low_o,
  output logic       sda_low_o,
  output logic       active_o,
  output logic       done_o,
  output logic       fail_o,
  output logic [7:0] rdata_o
);
  spd_phase_e state;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [1:0] bytei;
  logic [7:0] txsh, rx, baddr_q;
  logic [6:0] dev_q;
  logic       err_q, scl_low_q, sda_low_q, done_q;

  function automatic logic [7:0] load_byte(input logic [1:0] idx,
                                           input logic [6:0] d,
                                           input logic [7:0] b);
    case (idx)
      2'd0:    load_byte = {d, 1'b0};
      2'd1:    load_byte = b;
      2'd2:    load_byte = {d, 1'b1};
      default: load_byte = 8'hFF;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PH_IDLE; q <= '0; bitn <= '0; bytei <= '0;
      txsh <= '0; rx <= '0; dev_q <= '0; baddr_q <= '0;
      err_q <= 1'b0; scl_low_q <= 1'b0; sda_low_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state == PH_IDLE) begin
        if (start_i) begin
          dev_q <= dev_i; baddr_q <= baddr_i;
          err_q <= 1'b0; bytei <= 2'd0; q <= 2'd0;
          state <= PH_START;
        end
      end else if (tick_i) begin
        q <= q + 2'd1;
        case (state)
          PH_START: begin
            case (q)
              2'd0: begin scl_low_q <= 1'b1; sda_low_q <= 1'b0; end
              2'd1: scl_low_q <= 1'b0;
              2'd2: sda_low_q <= 1'b1;
              default: begin
                scl_low_q <= 1'b1;
                state     <= PH_BYTE;
                bitn      <= 4'd0;
                txsh      <= load_byte(bytei, dev_q, baddr_q);
              end
            endcase
          end
          PH_BYTE: begin
            case (q)
              2'd0: begin
                scl_low_q <= 1'b1;
                sda_low_q <= (bitn != 4'd8 && bytei != 2'd3) ? ~txsh[7] : 1'b0;
              end
              2'd1: scl_low_q <= 1'b0;
              2'd2: begin
                if (bitn != 4'd8) rx <= {rx[6:0], sda_in_i};
                else if (bytei != 2'd3 && sda_in_i) err_q <= 1'b1;
              end
              default: begin
                scl_low_q <= 1'b1;
                if (bitn != 4'd8) begin
                  bitn <= bitn + 4'd1;
                  txsh <= {txsh[6:0], 1'b0};
                end else if (err_q || bytei == 2'd3) begin
                  state <= PH_STOP;
                end else if (bytei == 2'd1) begin
                  bytei <= 2'd2;
                  state <= PH_START;
                end else begin
                  bytei <= bytei + 2'd1;
                  bitn  <= 4'd0;
                  txsh  <= load_byte(bytei + 2'd1, dev_q, baddr_q);
                end
              end
            endcase
          end
          default: begin  // PH_STOP
            case (q)
              2'd0: begin scl_low_q <= 1'b1; sda_low_q <= 1'b1; end
              2'd1: scl_low_q <= 1'b0;
              2'd2: sda_low_q <= 1'b0;
              default: begin state <= PH_IDLE; done_q <= 1'b1; end
            endcase
          end
        endcase
      end
    end
  end

  assign scl_low_o = scl_low_q;
  assign sda_low_o = sda_low_q;
  assign active_o  = (state != PH_IDLE);
  assign done_o    = done_q;
  assign fail_o    = err_q;
  assign rdata_o   = rx;

  AST_SDA_HIGH_SCL_ONLY_COND: assert property (@(posedge clk) disable iff (rst)
    (!scl_low_q && !$past(scl_low_q) && (sda_low_q != $past(sda_low_q)))
      |-> (state == PH_START || state == PH_STOP)); // R7
  AST_IDLE_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == PH_IDLE) |-> (!scl_low_q && !sda_low_q)); // R9
  AST_START_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (state == PH_IDLE)); // R4
endmodule

// File: rtl/spd_read_engine.sv
module spd_read_engine
  import spd_pkg::*;
#(
  parameter int QDIV = 125
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [15:0] stat_rdata,
  output logic        scl_drive_low,
  output logic        sda_drive_low,
  input  logic        sda_in
);
  localparam int BUSY_MIN = SLOTS_PER_READ * QUARTERS * QDIV;
  localparam int BUSY_MAX = BUSY_MIN + 4;
  localparam int BW       = $clog2(BUSY_MAX + 2);

  logic       busy_r, valid_r, err_r;
  logic [7:0] data_r;
  logic       accept, tick, seq_active, seq_done, seq_fail;
  logic [7:0] seq_rdata;
  logic       unused_cmd_bits;

  assign accept          = cmd_we && !busy_r && !cmd_wdata[0];
  assign unused_cmd_bits = ^{cmd_wdata[27], cmd_wdata[15:1]};

  spd_qtick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst(rst), .run_i(seq_active), .tick_o(tick)
  );

  spd_seq u_seq (
    .clk(clk), .rst(rst), .start_i(accept),
    .dev_i({cmd_wdata[31:28], cmd_wdata[26:24]}), .baddr_i(cmd_wdata[23:16]),
    .tick_i(tick), .sda_in_i(sda_in),
    .scl_low_o(scl_drive_low), .sda_low_o(sda_drive_low),
    .active_o(seq_active), .done_o(seq_done), .fail_o(seq_fail),
    .rdata_o(seq_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_r <= 1'b0; valid_r <= 1'b0; err_r <= 1'b0; data_r <= '0;
    end else if (accept) begin
      busy_r <= 1'b1; valid_r <= 1'b0; err_r <= 1'b0; data_r <= '0;
    end else if (seq_done) begin
      busy_r  <= 1'b0;
      valid_r <= !seq_fail;
      err_r   <= seq_fail;
      data_r  <= seq_fail ? 8'h00 : seq_rdata;
    end
  end

  always_comb begin
    stat_rdata               = '0;
    stat_rdata[ST_VALID_BIT] = valid_r;
    stat_rdata[ST_ERR_BIT]   = err_r;
    stat_rdata[ST_BUSY_BIT]  = busy_r;
    stat_rdata[7:0]          = data_r;
  end

  logic [BW-1:0] busy_cyc;
  always_ff @(posedge clk) begin
    if (rst || !busy_r) busy_cyc <= '0;
    else if (busy_cyc != {BW{1'b1}}) busy_cyc <= busy_cyc + 1'b1;
  end

  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    busy_cyc <= BW'(BUSY_MAX)); // R8
  AST_ACCEPT_STARTS_BUS: assert property (@(posedge clk) disable iff (rst)
    accept |=> seq_active); // R3
  AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(valid_r && err_r)); // R6
endmodule

// File: tb/spd_read_engine_tb.sv
module spd_read_engine_tb;
  localparam int QDIV   = 4;
  localparam int BMIN   = 156 * QDIV;
  localparam int BMAX   = BMIN + 4;
  localparam logic [2:0] SLV_SA = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [15:0] stat_rdata;
  logic scl_drive_low, sda_drive_low;
  logic slv_low = 1'b0;
  logic scl_line, sda_line;

  assign scl_line = ~scl_drive_low;
  assign sda_line = ~(sda_drive_low | slv_low);

  always #10 clk = ~clk;

  spd_read_engine #(.QDIV(QDIV)) u_dut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .stat_rdata(stat_rdata), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .sda_in(sda_line)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cond_edges = 0;

  function automatic logic [7:0] mem(input logic [7:0] a);
    mem = a * 8'd37 + 8'h1B;
  endfunction

  // ---------------- EEPROM model ----------------
  int sphase = 0;   // 0 idle,1 addr,2 byte addr,3 wait,4 read data,5 read pending
  int bcnt = 0;
  logic [7:0] sh = '0, ptr = '0, rdbyte = '0;
  logic nack_baddr = 1'b0, nack_raddr = 1'b0;

  always @(negedge sda_line) if (scl_line) begin sphase = 1; bcnt = 0; slv_low = 1'b0; end
  always @(posedge sda_line) if (scl_line) begin sphase = 0; end
  always @(sda_line) if (scl_line === 1'b1 && !rst) cond_edges++;

  always @(posedge scl_line) if (sphase != 0) begin
    if (bcnt < 8) sh = {sh[6:0], sda_line};
    if (bcnt < 9) bcnt++;
  end

  always @(negedge scl_line) if (sphase != 0) begin
    if (bcnt == 9) begin
      slv_low = 1'b0; bcnt = 0;
      if (sphase == 5) begin
        sphase = 4; rdbyte = mem(ptr); slv_low = ~rdbyte[7];
      end else if (sphase == 4) sphase = 0;
    end else if (sphase == 4) begin
      if (bcnt < 8) slv_low = ~rdbyte[7-bcnt];
      else slv_low = 1'b0;
    end else if (bcnt == 8) begin
      if (sphase == 1) begin
        if (sh[7:1] == {4'hA, SLV_SA}) begin
          if (sh[0]) begin
            if (!nack_raddr) begin slv_low = 1'b1; sphase = 5; end else sphase = 0;
          end else begin slv_low = 1'b1; sphase = 2; end
        end else sphase = 0;
      end else if (sphase == 2) begin
        ptr = sh;
        if (!nack_baddr) begin slv_low = 1'b1; sphase = 3; end else sphase = 0;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (stat_rdata[12] && cyc < 5000) begin @(negedge clk); cyc++; end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] dt, input logic [2:0] sa,
                                     input logic [7:0] ba, input int junk);
    mk = {dt, 1'(junk), sa, ba, 8'(junk * 3), 7'(junk), 1'b0};
  endfunction

  task automatic run_read(input logic [31:0] w, input logic [15:0] exp_stat,
                          input int exp_edges, input bit full);
    int cyc;
    cond_edges = 0;
    issue(w);
    check(stat_rdata == 16'h1000, "R3 busy on accept", stat_rdata, 16'h1000);
    wait_idle(cyc);
    check(stat_rdata == exp_stat, full ? "R2 read status" : "R6 nack status",
          stat_rdata, exp_stat);
    check(cond_edges == exp_edges, "R7 sda edges while scl high", cond_edges, exp_edges);
    check(scl_line && sda_line, "R9 lines released when idle", {scl_line, sda_line}, 3);
    if (full) check(cyc >= BMIN && cyc <= BMAX, "R8 busy duration", cyc, BMIN);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog expired actual=0x0 expected=0x1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] held;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(stat_rdata == 16'h0000, "R1 reset status", stat_rdata, 0);
    check(scl_line && sda_line, "R1 lines after reset", {scl_line, sda_line}, 3);

    // R2 address sweep, junk in ignored fields varies
    for (int i = 0; i < 38; i++) begin
      logic [7:0] a = 8'(i * 53);
      run_read(mk(4'hA, SLV_SA, a, i), 16'h8000 | 16'(mem(a)), 3, 1'b1);
    end
    run_read(mk(4'hA, SLV_SA, 8'hFF, 5), 16'h8000 | 16'(mem(8'hFF)), 3, 1'b1);

    // R6 missing acks
    run_read(mk(4'hA, 3'd2, 8'h10, 1), 16'h2000, 2, 1'b0);   // wrong select
    run_read(mk(4'h5, SLV_SA, 8'h10, 2), 16'h2000, 2, 1'b0); // wrong type
    nack_baddr = 1'b1;
    run_read(mk(4'hA, SLV_SA, 8'h22, 3), 16'h2000, 2, 1'b0);
    nack_baddr = 1'b0; nack_raddr = 1'b1;
    run_read(mk(4'hA, SLV_SA, 8'h33, 4), 16'h2000, 3, 1'b0);
    nack_raddr = 1'b0;
    // R3 recovery after error
    run_read(mk(4'hA, SLV_SA, 8'h44, 6), 16'h8000 | 16'(mem(8'h44)), 3, 1'b1);

    // R4 command while busy is ignored
    issue(mk(4'hA, SLV_SA, 8'h40, 0));
    repeat (100) @(negedge clk);
    issue(mk(4'hA, 3'd2, 8'h41, 0));
    check(stat_rdata == 16'h1000, "R4 status during busy", stat_rdata, 16'h1000);
    wait_idle(cyc);
    check(stat_rdata == (16'h8000 | 16'(mem(8'h40))), "R4 first command wins",
          stat_rdata, 16'h8000 | 16'(mem(8'h40)));

    // R5 command bit set is ignored
    held = stat_rdata;
    issue(mk(4'hA, SLV_SA, 8'h10, 0) | 32'h1);
    check(stat_rdata == held, "R5 status unchanged", stat_rdata, held);
    repeat (40) @(negedge clk);
    check(stat_rdata == held, "R5 still unchanged", stat_rdata, held);
    check(scl_line && sda_line, "R5 bus untouched", {scl_line, sda_line}, 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule